// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple 32-bit processor core and chooses where execution goes next. On each cycle it receives the instruction held at the current PC and the values of that instruction's two source registers. From these it works out the following address. That address is sequential, a compare-and-branch target relative to the PC, a jump target inside the current 256 MiB region, or an address read from a register. When the step input is high the PC register loads that address on the next clock edge. When step is low the PC holds.

For the linking forms the block also presents the return address, which is the current PC plus four, together with the index of the register that should receive it and a write strobe. The register file consumes these three outputs. A register jump to an address that is not word aligned raises a misalignment flag. The address is still followed, so a trap unit can respond to it.

Top module: `next_pc_unit`

## Requirements
- R1: After reset (rst_n low, asynchronous) the PC equals the RESET_VEC parameter.
- R2: While step is low the PC keeps its value across clock edges.
- R3: For any instruction that is not a control transfer, the next PC is PC+4, and the PC takes that value on the clock edge where step is high.
- R4: Opcode 4 (bits 31:26) with rs_val equal to rt_val gives a next PC of PC+4 plus the sign-extended 16-bit field (bits 15:0) times 4. With unequal values the next PC is PC+4.
- R5: Opcode 5 takes the same branch target when rs_val differs from rt_val. It gives PC+4 when they are equal.
- R6: Opcodes 2 and 3 give a next PC made of PC bits 31:28, followed by the 26-bit field (bits 25:0), followed by two zero bits.
- R7: Opcode 3 asserts link_we with link_idx 31 and link_val PC+4. Non-linking instructions hold link_we low.
- R8: Opcode 0 with function code 8 (bits 5:0) gives next PC = rs_val. Function code 9 does the same and asserts link_we with link_idx = bits 15:11 and link_val = PC+4.
- R9: misalign is high exactly when a register jump (opcode 0, function 8 or 9) has a target whose low two bits are not zero.
- R10: Opcode 0 with any other function code is sequential and links nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Load the next PC on this edge |
| instr | input | 32 | Instruction at the current PC |
| rs_val | input | ADDR_W | Value of the first source register |
| rt_val | input | ADDR_W | Value of the second source register |
| pc | output | ADDR_W | Current program counter |
| next_pc | output | ADDR_W | Address that the next step will load |
| link_we | output | 1 | Return address write strobe |
| link_idx | output | 5 | Register receiving the return address |
| link_val | output | ADDR_W | Return address (PC+4) |
| misalign | output | 1 | Register jump target not word aligned |

## Verification
The bench builds the unit with RESET_VEC set to 32'hA000_0100 and CHECK_ALIGN set to 1. The nonzero upper nibble of that vector makes region-preserving jumps distinguishable from jumps that drop the upper bits. A 26-bit jump field of all ones then lands at the very top of that region. The enabled alignment check exposes the misalignment flag. A branch with the most negative offset then wraps the PC below zero, which tests the sign extension of the 16-bit field.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int INSTR_W  = 32;
   localparam int OPC_W    = 6;
   localparam int FN_W     = 6;
   localparam int RIDX_W   = 5;
   localparam int OFFS_W   = 16;
   localparam int JIDX_W   = 26;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JLINK   = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BREQ    = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BRNE    = 6'd5;
   localparam logic [FN_W-1:0]  FN_RJUMP    = 6'd8;
   localparam logic [FN_W-1:0]  FN_RJLINK   = 6'd9;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BREQ,
      FLOW_BRNE,
      FLOW_JUMP,
      FLOW_JLINK,
      FLOW_RJUMP,
      FLOW_RJLINK
   } flow_e;

   typedef struct packed {
      flow_e              flow;
      logic [OFFS_W-1:0]  offs;
      logic [JIDX_W-1:0]  jidx;
      logic [RIDX_W-1:0]  rd;
   } dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);
   logic [OPC_W-1:0] opc;
   logic [FN_W-1:0]  fn;

   assign opc = instr[INSTR_W-1 -: OPC_W];
   assign fn  = instr[FN_W-1:0];

   always_comb begin
      dec.offs = instr[OFFS_W-1:0];
      dec.jidx = instr[JIDX_W-1:0];
      dec.rd   = instr[15:11];
      unique case (opc)
         OPC_BREQ:  dec.flow = FLOW_BREQ;
         OPC_BRNE:  dec.flow = FLOW_BRNE;
         OPC_JUMP:  dec.flow = FLOW_JUMP;
         OPC_JLINK: dec.flow = FLOW_JLINK;
         OPC_SPECIAL: begin
            if (fn == FN_RJUMP)       dec.flow = FLOW_RJUMP;
            else if (fn == FN_RJLINK) dec.flow = FLOW_RJLINK;
            else                      dec.flow = FLOW_SEQ;
         end
         default:   dec.flow = FLOW_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINK_IDX = 31
) (
   input  logic [ADDR_W-1:0] pc,
   input  dec_t              dec,
   input  logic [ADDR_W-1:0] rs_val,
   input  logic [ADDR_W-1:0] rt_val,
   output logic [ADDR_W-1:0] next_pc,
   output logic              link_we,
   output logic [RIDX_W-1:0] link_idx,
   output logic [ADDR_W-1:0] link_val,
   output logic              reg_jump
);
   localparam int SEXT_W = ADDR_W - OFFS_W - 2;
   localparam int REG_W  = ADDR_W - JIDX_W - 2;

   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] br_pc;
   logic [ADDR_W-1:0] jmp_pc;
   logic              same;

   assign seq_pc = pc + ADDR_W'(4);
   assign br_pc  = seq_pc + {{SEXT_W{dec.offs[OFFS_W-1]}}, dec.offs, 2'b00};
   assign jmp_pc = {pc[ADDR_W-1 -: REG_W], dec.jidx, 2'b00};
   assign same   = (rs_val == rt_val);

   always_comb begin
      next_pc  = seq_pc;
      link_we  = 1'b0;
      link_idx = '0;
      reg_jump = 1'b0;
      unique case (dec.flow)
         FLOW_BREQ:   if (same)  next_pc = br_pc;
         FLOW_BRNE:   if (!same) next_pc = br_pc;
         FLOW_JUMP:   next_pc = jmp_pc;
         FLOW_JLINK: begin
            next_pc  = jmp_pc;
            link_we  = 1'b1;
            link_idx = RIDX_W'(LINK_IDX);
         end
         FLOW_RJUMP: begin
            next_pc  = rs_val;
            reg_jump = 1'b1;
         end
         FLOW_RJLINK: begin
            next_pc  = rs_val;
            reg_jump = 1'b1;
            link_we  = 1'b1;
            link_idx = dec.rd;
         end
         default: next_pc = seq_pc;
      endcase
   end

   assign link_val = seq_pc;
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
   parameter int              ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= RESET_VEC;
      else if (step) pc <= next_pc;
   end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
   import npc_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0040_0000,
   parameter int                LINK_IDX    = 31,
   parameter bit                CHECK_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] rs_val,
   input  logic [ADDR_W-1:0] rt_val,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] next_pc,
   output logic              link_we,
   output logic [4:0]        link_idx,
   output logic [ADDR_W-1:0] link_val,
   output logic              misalign
);
   if (ADDR_W <= JIDX_W + 2) begin : g_bad_width
      $error("ADDR_W must exceed the jump field plus two bits");
   end
   if (LINK_IDX < 0 || LINK_IDX >= (1 << RIDX_W)) begin : g_bad_link
      $error("LINK_IDX must name an existing register");
   end
   if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("RESET_VEC must be word aligned");
   end

   dec_t dec;
   logic reg_jump;

   npc_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   npc_target #(
      .ADDR_W   (ADDR_W),
      .LINK_IDX (LINK_IDX)
   ) u_tgt (
      .pc       (pc),
      .dec      (dec),
      .rs_val   (rs_val),
      .rt_val   (rt_val),
      .next_pc  (next_pc),
      .link_we  (link_we),
      .link_idx (link_idx),
      .link_val (link_val),
      .reg_jump (reg_jump)
   );

   npc_pc_reg #(
      .ADDR_W    (ADDR_W),
      .RESET_VEC (RESET_VEC)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .next_pc (next_pc),
      .pc      (pc)
   );

   if (CHECK_ALIGN) begin : g_align
      assign misalign = reg_jump & (|rs_val[1:0]);
   end else begin : g_no_align
      assign misalign = 1'b0;
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> pc == $past(pc));

   // R3
   load_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> pc == $past(next_pc));

   // R7
   link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_val == pc + ADDR_W'(4));

   // R9
   misalign_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (next_pc[1:0] != 2'b00 && next_pc == rs_val));

   // R8
   reg_link_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr[31:26] == 6'd0 && instr[5:0] == 6'd9) |-> (link_we && link_idx == instr[15:11]));
endmodule

// File: tb/next_pc_unit_bench.sv
module next_pc_unit_bench;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] RVEC       = 32'hA000_0100;

   typedef struct packed {
      logic [31:0] instr;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] nxt;
      logic        lwe;
      logic [4:0]  lidx;
      logic [31:0] lval;
      logic        mis;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{32'h2129_FFFD, 32'h0,        32'h0, 32'hA000_0104, 1'b0, 5'd0,  32'hA000_0104, 1'b0}, // R3
      '{32'h1000_0003, 32'h5,        32'h5, 32'hA000_0114, 1'b0, 5'd0,  32'hA000_0108, 1'b0}, // R4 taken
      '{32'h1000_0003, 32'h1,        32'h2, 32'hA000_0118, 1'b0, 5'd0,  32'hA000_0118, 1'b0}, // R4 not taken
      '{32'h1400_FFFE, 32'h1,        32'h2, 32'hA000_0114, 1'b0, 5'd0,  32'hA000_011C, 1'b0}, // R5 taken back
      '{32'h1400_FFFE, 32'h7,        32'h7, 32'hA000_0118, 1'b0, 5'd0,  32'hA000_0118, 1'b0}, // R5 not taken
      '{32'h0800_0040, 32'h0,        32'h0, 32'hA000_0100, 1'b0, 5'd0,  32'hA000_011C, 1'b0}, // R6
      '{32'h0FFF_FFFF, 32'h0,        32'h0, 32'hAFFF_FFFC, 1'b1, 5'd31, 32'hA000_0104, 1'b0}, // R6 R7
      '{32'h0000_0008, 32'h0000_2000, 32'h0, 32'h0000_2000, 1'b0, 5'd0,  32'hB000_0000, 1'b0}, // R8 jr
      '{32'h0000_2809, 32'h0000_3000, 32'h0, 32'h0000_3000, 1'b1, 5'd5,  32'h0000_2004, 1'b0}, // R8 jalr
      '{32'h0000_0020, 32'h0000_4000, 32'h0, 32'h0000_3004, 1'b0, 5'd0,  32'h0000_3004, 1'b0}, // R10
      '{32'h1000_8000, 32'h9,        32'h9, 32'hFFFE_3008, 1'b0, 5'd0,  32'h0000_3008, 1'b0}, // R4 min offset
      '{32'h0000_0008, 32'h0000_5002, 32'h0, 32'h0000_5002, 1'b0, 5'd0,  32'hFFFE_300C, 1'b1}  // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc, next_pc, link_val;
   logic        link_we, misalign;
   logic [4:0]  link_idx;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   next_pc_unit #(
      .ADDR_W      (32),
      .RESET_VEC   (RVEC),
      .LINK_IDX    (31),
      .CHECK_ALIGN (1'b1)
   ) u_next_pc_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .instr    (instr),
      .rs_val   (rs_val),
      .rt_val   (rt_val),
      .pc       (pc),
      .next_pc  (next_pc),
      .link_we  (link_we),
      .link_idx (link_idx),
      .link_val (link_val),
      .misalign (misalign)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset pc", pc, RVEC);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pc after release", pc, RVEC);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         instr  = TBL[i].instr;
         rs_val = TBL[i].rs;
         rt_val = TBL[i].rt;
         step   = 1'b1;
         #1;
         chk($sformatf("R3-R10 vec%0d next_pc", i), next_pc, TBL[i].nxt);
         chk($sformatf("R7 vec%0d link_we", i), {31'b0, link_we}, {31'b0, TBL[i].lwe});
         if (TBL[i].lwe) begin
            chk($sformatf("R7 R8 vec%0d link_idx", i), {27'b0, link_idx}, {27'b0, TBL[i].lidx});
            chk($sformatf("R7 R8 vec%0d link_val", i), link_val, TBL[i].lval);
         end
         chk($sformatf("R9 vec%0d misalign", i), {31'b0, misalign}, {31'b0, TBL[i].mis});
         @(posedge clk);
         #1;
         chk($sformatf("R3 vec%0d pc loaded", i), pc, TBL[i].nxt);
      end

      // R2: step low holds the PC even with a jump presented
      @(negedge clk);
      step  = 1'b0;
      instr = 32'h0800_0000;
      repeat (3) @(posedge clk);
      #1;
      chk("R2 hold pc", pc, 32'h0000_5002);

      // R10: register-form op with other function links nothing
      instr = 32'h0000_F809;
      instr[5:0] = 6'd10;
      #1;
      chk("R10 no link", {31'b0, link_we}, 32'd0);
      chk("R10 sequential", next_pc, 32'h0000_5006);

      // R1: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 async reset", pc, RVEC);
      rst_n = 1'b1;

      done = 1'b1;
      report();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         report();
      end
   end
endmodule